// File: doc/BRIEF.md
# Nibble Accumulator Execution Core

This block is a compact 4-bit execution engine. Each clock cycle it presents a program address and takes one instruction byte back on the same cycle. It decodes the byte and executes a fixed set of data-movement, rotate and arithmetic operations. The architectural state is a 4-bit accumulator, two 4-bit pointer nibbles (a high pointer and a low pointer), and three flags: carry, zero and status. A 256-nibble data RAM lives inside the block. It is reached by an 8-bit direct address, by a 4-bit page-zero address, or indirectly through the pointer pair.

Opcodes whose high nibble is 0100 or 0110 occupy two bytes and take two cycles. Every other opcode is one byte and one cycle. The program counter moves forward by one on every cycle, and the core never stalls. The status flag carries the outcome of each operation: it may be forced to 1, take a carry-out, take a wrap indication, or take the bit shifted out. Opcodes outside the supported set execute as no-ops of the length that their high nibble implies.

Top module: `nib_exec_core`

## Requirements
- R1: While reset is asserted, the accumulator, both pointer nibbles and all three flags read 0, and the program address reads 0.
- R2: The program address advances by one every cycle. A byte whose high nibble is 0100 or 0110 is an opcode that takes the next byte as its operand, so `retire` is low in the cycle that first byte is presented and high in the next. Every other opcode retires in the cycle it is presented.
- R3: One-byte immediates carry the value k in their low nibble. Opcode 0xD_ loads the accumulator with k, updates zero and sets status. Opcode 0x8_ loads the low pointer with k and sets status. Opcode 0x9_ loads the high pointer with k and sets status.
- R4: 0x6A followed by an address byte loads the accumulator from RAM at that address, updates zero and sets status. 0x69 followed by an address byte stores the accumulator at that address and sets status, leaving zero unchanged.
- R5: The indirect address is {high pointer, low pointer}. 0x5A loads the accumulator from that address, updates zero and sets status. 0x59 stores the accumulator there and sets status.
- R6: 0x7F stores the accumulator indirectly and then adds 1 to the low pointer. 0x7D stores it and then subtracts 1. 0xA_ stores k indirectly and then adds 1. The low pointer wraps modulo 16 and never changes the high pointer. Zero reflects the new low pointer, and status is 1 exactly when the step wrapped.
- R7: 0x4E followed by an address byte clears the two low bits of that address to form a base. It loads the low pointer from RAM[base] and the high pointer from RAM[base+1], and sets status; zero is left unchanged.
- R8: 0x48 followed by the byte {k,y} writes k to RAM[y] in page zero and sets status. 0x49 followed by {k,y} adds k to RAM[y] modulo 16, updates zero and sets status to the carry-out.
- R9: 0x76 copies the high pointer into the accumulator and 0x74 copies the low pointer. Both update zero and set status.
- R10: 0x50 rotates {carry, accumulator} left and 0x51 rotates it right. The bit shifted out of the accumulator goes to both carry and status, and zero reflects the new accumulator.
- R11: 0x70 adds the indirect RAM nibble plus carry to the accumulator and updates carry, zero and status (status takes the carry-out). 0x71 adds without carry-in, leaves carry unchanged, and sets status to the carry-out.
- R12: 0x6E followed by {sel,k} adds k to the target that sel picks: 0101 picks the accumulator, 1001 the high pointer, 0001 the low pointer and 1101 the indirect RAM nibble. Zero follows the result and status takes the carry-out. Any other sel is a no-op.
- R13: 0x5C decrements the accumulator, 0x7C decrements the low pointer and 0x5D decrements the indirect RAM nibble. 0x5E increments the accumulator. Zero follows the result, status is 1 exactly when the value wrapped, and carry is unchanged.
- R14: Any opcode outside the set above changes no register, flag or RAM cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progData | input | 8 | Program byte at `progAddr`, valid in the same cycle |
| progAddr | output | PC_W | Program counter |
| retire | output | 1 | High in the cycle an instruction executes |
| accOut | output | 4 | Accumulator |
| hrOut | output | 4 | High pointer nibble |
| lrOut | output | 4 | Low pointer nibble |
| carryFlag | output | 1 | Carry flag |
| zeroFlag | output | 1 | Zero flag |
| statusFlag | output | 1 | Status flag |

## Verification
The bench builds the core with PC_W set to 8. A 256-byte program space then holds the whole vector program: 53 bytes mixing one- and two-byte opcodes. The data RAM width follows from the nibble size, so RAM cells in page zero, in the direct range and in high pointer pages 2, 3 and 9 are all reachable. The vectors drive the low pointer across both wrap points, push the accumulator and RAM cells through carry-out, and run unknown one-byte opcodes, unknown two-byte opcodes and an unknown 0x6E selector.

// File: rtl/nib_exec_pkg.sv
package nib_exec_pkg;
  localparam int NIB_W = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int RAM_AW = 2 * NIB_W;
  localparam int RAM_DEPTH = 1 << RAM_AW;

  typedef enum logic [4:0] {
    OP_NOP, OP_LDA_DIR, OP_STA_DIR, OP_LDA_HL, OP_STA_HL,
    OP_STA_HL_INC, OP_STA_HL_DEC, OP_STI_HL_INC, OP_LDHL,
    OP_STD_PG0, OP_ADD_PG0, OP_THA, OP_TLA, OP_RLC, OP_RRC,
    OP_ADC_HL, OP_ADD_HL, OP_ADDI_A, OP_ADDI_H, OP_ADDI_L,
    OP_ADDI_M, OP_DEC_A, OP_DEC_L, OP_DEC_M, OP_INC_A,
    OP_LDI_A, OP_LDI_L, OP_LDI_H
  } op_e;

  typedef struct packed {
    logic              exec;
    op_e               op;
    logic [BYTE_W-1:0] arg;
  } strobe_t;
endpackage

// File: rtl/nib_exec_ctrl.sv
module nib_exec_ctrl
  import nib_exec_pkg::*;
#(
  parameter int PC_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] progData,
  output logic [PC_W-1:0]   progAddr,
  output strobe_t           strobe
);
  logic [PC_W-1:0]   pc;
  logic              waitArg;
  logic [BYTE_W-1:0] firstByte;
  logic              isTwo;
  logic [BYTE_W-1:0] opByte;
  logic [BYTE_W-1:0] argByte;

  function automatic op_e decodeOp(input logic [BYTE_W-1:0] o, input logic [BYTE_W-1:0] a);
    op_e r;
    case (o)
      8'h6A: r = OP_LDA_DIR;
      8'h69: r = OP_STA_DIR;
      8'h5A: r = OP_LDA_HL;
      8'h59: r = OP_STA_HL;
      8'h7F: r = OP_STA_HL_INC;
      8'h7D: r = OP_STA_HL_DEC;
      8'h4E: r = OP_LDHL;
      8'h48: r = OP_STD_PG0;
      8'h49: r = OP_ADD_PG0;
      8'h76: r = OP_THA;
      8'h74: r = OP_TLA;
      8'h50: r = OP_RLC;
      8'h51: r = OP_RRC;
      8'h70: r = OP_ADC_HL;
      8'h71: r = OP_ADD_HL;
      8'h5C: r = OP_DEC_A;
      8'h7C: r = OP_DEC_L;
      8'h5D: r = OP_DEC_M;
      8'h5E: r = OP_INC_A;
      8'h6E: begin
        case (a[BYTE_W-1:NIB_W])
          4'b0101: r = OP_ADDI_A;
          4'b1001: r = OP_ADDI_H;
          4'b0001: r = OP_ADDI_L;
          4'b1101: r = OP_ADDI_M;
          default: r = OP_NOP;
        endcase
      end
      default: begin
        case (o[BYTE_W-1:NIB_W])
          4'b1101: r = OP_LDI_A;
          4'b1000: r = OP_LDI_L;
          4'b1001: r = OP_LDI_H;
          4'b1010: r = OP_STI_HL_INC;
          default: r = OP_NOP;
        endcase
      end
    endcase
    return r;
  endfunction

  assign isTwo = !waitArg &&
                 ((progData[BYTE_W-1:NIB_W] == 4'b0100) || (progData[BYTE_W-1:NIB_W] == 4'b0110));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc        <= '0;
      waitArg   <= 1'b0;
      firstByte <= '0;
    end else begin
      pc <= pc + 1'b1;
      if (waitArg) begin
        waitArg <= 1'b0;
      end else if (isTwo) begin
        waitArg   <= 1'b1;
        firstByte <= progData;
      end
    end
  end

  always_comb begin
    opByte  = waitArg ? firstByte : progData;
    argByte = waitArg ? progData : {{NIB_W{1'b0}}, progData[NIB_W-1:0]};
    strobe.exec = waitArg || !isTwo;
    strobe.op   = strobe.exec ? decodeOp(opByte, argByte) : OP_NOP;
    strobe.arg  = argByte;
  end

  assign progAddr = pc;
endmodule

// File: rtl/nib_exec_dp.sv
module nib_exec_dp
  import nib_exec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  output logic [NIB_W-1:0] accOut,
  output logic [NIB_W-1:0] hrOut,
  output logic [NIB_W-1:0] lrOut,
  output logic             carryFlag,
  output logic             zeroFlag,
  output logic             statusFlag
);
  logic [NIB_W-1:0]  acc, hr, lr;
  logic              cf, zf, sf;
  logic [NIB_W-1:0]  mem [RAM_DEPTH];

  logic [NIB_W-1:0]  nAcc, nHr, nLr;
  logic              nC, nZ, nS;
  logic              memWe;
  logic [RAM_AW-1:0] wAddr, rdAddr, hlAddr, pairBase, pairNext, pg0Addr;
  logic [NIB_W-1:0]  wData, rdData, rdHi;
  logic [NIB_W:0]    res, lrUp, lrDown;
  logic [NIB_W-1:0]  argLo, argHi;

  assign argLo    = strobe.arg[NIB_W-1:0];
  assign argHi    = strobe.arg[BYTE_W-1:NIB_W];
  assign hlAddr   = {hr, lr};
  assign pairBase = {strobe.arg[BYTE_W-1:2], 2'b00};
  assign pairNext = {strobe.arg[BYTE_W-1:2], 2'b01};
  assign pg0Addr  = {{(RAM_AW-NIB_W){1'b0}}, argLo};
  assign lrUp     = {1'b0, lr} + 1'b1;
  assign lrDown   = {1'b0, lr} - 1'b1;

  always_comb begin
    case (strobe.op)
      OP_LDA_DIR:             rdAddr = strobe.arg;
      OP_LDHL:                rdAddr = pairBase;
      OP_ADD_PG0:             rdAddr = pg0Addr;
      default:                rdAddr = hlAddr;
    endcase
  end

  assign rdData = mem[rdAddr];
  assign rdHi   = mem[pairNext];

  always_comb begin
    nAcc  = acc;
    nHr   = hr;
    nLr   = lr;
    nC    = cf;
    nZ    = zf;
    nS    = sf;
    memWe = 1'b0;
    wAddr = hlAddr;
    wData = acc;
    res   = '0;
    case (strobe.op)
      OP_LDA_DIR, OP_LDA_HL: begin
        nAcc = rdData; nZ = (rdData == '0); nS = 1'b1;
      end
      OP_STA_DIR: begin
        memWe = 1'b1; wAddr = strobe.arg; nS = 1'b1;
      end
      OP_STA_HL: begin
        memWe = 1'b1; nS = 1'b1;
      end
      OP_STA_HL_INC, OP_STI_HL_INC: begin
        memWe = 1'b1;
        if (strobe.op == OP_STI_HL_INC) wData = argLo;
        nLr = lrUp[NIB_W-1:0]; nZ = (lrUp[NIB_W-1:0] == '0); nS = lrUp[NIB_W];
      end
      OP_STA_HL_DEC: begin
        memWe = 1'b1;
        nLr = lrDown[NIB_W-1:0]; nZ = (lrDown[NIB_W-1:0] == '0); nS = lrDown[NIB_W];
      end
      OP_LDHL: begin
        nLr = rdData; nHr = rdHi; nS = 1'b1;
      end
      OP_STD_PG0: begin
        memWe = 1'b1; wAddr = pg0Addr; wData = argHi; nS = 1'b1;
      end
      OP_ADD_PG0: begin
        res = {1'b0, rdData} + {1'b0, argHi};
        memWe = 1'b1; wAddr = pg0Addr; wData = res[NIB_W-1:0];
        nZ = (res[NIB_W-1:0] == '0); nS = res[NIB_W];
      end
      OP_THA, OP_TLA: begin
        nAcc = (strobe.op == OP_THA) ? hr : lr;
        nZ = (nAcc == '0); nS = 1'b1;
      end
      OP_RLC: begin
        nAcc = {acc[NIB_W-2:0], cf}; nC = acc[NIB_W-1]; nS = acc[NIB_W-1];
        nZ = (nAcc == '0);
      end
      OP_RRC: begin
        nAcc = {cf, acc[NIB_W-1:1]}; nC = acc[0]; nS = acc[0];
        nZ = (nAcc == '0);
      end
      OP_ADC_HL, OP_ADD_HL: begin
        res = {1'b0, acc} + {1'b0, rdData} + {{NIB_W{1'b0}}, (strobe.op == OP_ADC_HL) & cf};
        nAcc = res[NIB_W-1:0]; nZ = (nAcc == '0); nS = res[NIB_W];
        if (strobe.op == OP_ADC_HL) nC = res[NIB_W];
      end
      OP_ADDI_A: begin
        res = {1'b0, acc} + {1'b0, argLo};
        nAcc = res[NIB_W-1:0]; nZ = (nAcc == '0); nS = res[NIB_W];
      end
      OP_ADDI_H: begin
        res = {1'b0, hr} + {1'b0, argLo};
        nHr = res[NIB_W-1:0]; nZ = (nHr == '0); nS = res[NIB_W];
      end
      OP_ADDI_L: begin
        res = {1'b0, lr} + {1'b0, argLo};
        nLr = res[NIB_W-1:0]; nZ = (nLr == '0); nS = res[NIB_W];
      end
      OP_ADDI_M: begin
        res = {1'b0, rdData} + {1'b0, argLo};
        memWe = 1'b1; wData = res[NIB_W-1:0];
        nZ = (res[NIB_W-1:0] == '0); nS = res[NIB_W];
      end
      OP_DEC_A: begin
        res = {1'b0, acc} - 1'b1;
        nAcc = res[NIB_W-1:0]; nZ = (nAcc == '0); nS = res[NIB_W];
      end
      OP_DEC_L: begin
        nLr = lrDown[NIB_W-1:0]; nZ = (nLr == '0); nS = lrDown[NIB_W];
      end
      OP_DEC_M: begin
        res = {1'b0, rdData} - 1'b1;
        memWe = 1'b1; wData = res[NIB_W-1:0];
        nZ = (res[NIB_W-1:0] == '0); nS = res[NIB_W];
      end
      OP_INC_A: begin
        res = {1'b0, acc} + 1'b1;
        nAcc = res[NIB_W-1:0]; nZ = (nAcc == '0); nS = res[NIB_W];
      end
      OP_LDI_A: begin
        nAcc = argLo; nZ = (argLo == '0); nS = 1'b1;
      end
      OP_LDI_L: begin
        nLr = argLo; nS = 1'b1;
      end
      OP_LDI_H: begin
        nHr = argLo; nS = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0; hr <= '0; lr <= '0;
      cf <= 1'b0; zf <= 1'b0; sf <= 1'b0;
    end else if (strobe.exec) begin
      acc <= nAcc; hr <= nHr; lr <= nLr;
      cf <= nC; zf <= nZ; sf <= nS;
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && strobe.exec && memWe) mem[wAddr] <= wData;
  end

  assign accOut     = acc;
  assign hrOut      = hr;
  assign lrOut      = lr;
  assign carryFlag  = cf;
  assign zeroFlag   = zf;
  assign statusFlag = sf;
endmodule

// File: rtl/nib_exec_core.sv
module nib_exec_core
  import nib_exec_pkg::*;
#(
  parameter int PC_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] progData,
  output logic [PC_W-1:0]   progAddr,
  output logic              retire,
  output logic [NIB_W-1:0]  accOut,
  output logic [NIB_W-1:0]  hrOut,
  output logic [NIB_W-1:0]  lrOut,
  output logic              carryFlag,
  output logic              zeroFlag,
  output logic              statusFlag
);
  strobe_t strobe;

  nib_exec_ctrl #(.PC_W(PC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .progData(progData),
    .progAddr(progAddr), .strobe(strobe)
  );

  nib_exec_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .accOut(accOut), .hrOut(hrOut), .lrOut(lrOut),
    .carryFlag(carryFlag), .zeroFlag(zeroFlag), .statusFlag(statusFlag)
  );

  assign retire = strobe.exec;
endmodule

// File: rtl/nib_exec_chk.sv
module nib_exec_chk
  import nib_exec_pkg::*;
#(
  parameter int PC_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             exec,
  input op_e              op,
  input logic [PC_W-1:0]  progAddr,
  input logic             retire,
  input logic [NIB_W-1:0] accOut,
  input logic [NIB_W-1:0] hrOut,
  input logic [NIB_W-1:0] lrOut,
  input logic             carryFlag,
  input logic             zeroFlag,
  input logic             statusFlag
);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> progAddr == $past(progAddr) + 1'b1);

  assert_no_double_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    !retire |=> retire);

  assert_lr_step_keeps_hr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (exec && op == OP_STA_HL_INC) |=>
      (hrOut == $past(hrOut)) && (lrOut == $past(lrOut) + 1'b1));

  assert_tha_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    (exec && op == OP_THA) |=> statusFlag && (accOut == $past(hrOut)));

  assert_rotate_left_R10: assert property (@(posedge clk) disable iff (!rstN)
    (exec && op == OP_RLC) |=>
      (carryFlag == $past(accOut[NIB_W-1])) &&
      (accOut == {$past(accOut[NIB_W-2:0]), $past(carryFlag)}));

  assert_add_keeps_carry_R11: assert property (@(posedge clk) disable iff (!rstN)
    (exec && op == OP_ADD_HL) |=> carryFlag == $past(carryFlag));

  assert_zero_tracks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (exec && op == OP_LDI_A) |=> zeroFlag == (accOut == '0));

  assert_nop_stable_R14: assert property (@(posedge clk) disable iff (!rstN)
    (exec && op == OP_NOP) |=>
      $stable(accOut) && $stable(hrOut) && $stable(lrOut) &&
      $stable(carryFlag) && $stable(zeroFlag) && $stable(statusFlag));
endmodule

bind nib_exec_core nib_exec_chk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rstN(rstN), .exec(strobe.exec), .op(strobe.op),
  .progAddr(progAddr), .retire(retire), .accOut(accOut), .hrOut(hrOut),
  .lrOut(lrOut), .carryFlag(carryFlag), .zeroFlag(zeroFlag), .statusFlag(statusFlag)
);

// File: tb/nib_exec_core_tb_top.sv
module nib_exec_core_tb_top;
  localparam int PC_W = 8;
  localparam int NVEC = 40;

  typedef struct packed {
    logic [1:0] len;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [3:0] acc;
    logic [3:0] hr;
    logic [3:0] lr;
    logic       c;
    logic       z;
    logic       s;
    logic [3:0] req;
  } vec_t;

  // expected state after each instruction: acc, hr, lr, carry, zero, status
  localparam vec_t VEC [NVEC] = '{
    '{2'd1, 8'hD5, 8'h00, 4'h5, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{2'd1, 8'h92, 8'h00, 4'h5, 4'h2, 4'h0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{2'd1, 8'h8F, 8'h00, 4'h5, 4'h2, 4'hF, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{2'd1, 8'h7F, 8'h00, 4'h5, 4'h2, 4'h0, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 wrap up
    '{2'd1, 8'h7D, 8'h00, 4'h5, 4'h2, 4'hF, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 wrap down
    '{2'd1, 8'h7D, 8'h00, 4'h5, 4'h2, 4'hE, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{2'd1, 8'hAC, 8'h00, 4'h5, 4'h2, 4'hF, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
    '{2'd1, 8'h5A, 8'h00, 4'h5, 4'h2, 4'hF, 1'b0, 1'b0, 1'b1, 4'd5},  // R5
    '{2'd1, 8'h8E, 8'h00, 4'h5, 4'h2, 4'hE, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{2'd1, 8'h71, 8'h00, 4'h1, 4'h2, 4'hE, 1'b0, 1'b0, 1'b1, 4'd11}, // R11
    '{2'd1, 8'h70, 8'h00, 4'hD, 4'h2, 4'hE, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{2'd1, 8'hD9, 8'h00, 4'h9, 4'h2, 4'hE, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{2'd1, 8'h50, 8'h00, 4'h2, 4'h2, 4'hE, 1'b1, 1'b0, 1'b1, 4'd10}, // R10
    '{2'd1, 8'h51, 8'h00, 4'h9, 4'h2, 4'hE, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{2'd1, 8'h5C, 8'h00, 4'h8, 4'h2, 4'hE, 1'b0, 1'b0, 1'b0, 4'd13}, // R13
    '{2'd1, 8'hD0, 8'h00, 4'h0, 4'h2, 4'hE, 1'b0, 1'b1, 1'b1, 4'd3},  // R3
    '{2'd1, 8'h5C, 8'h00, 4'hF, 4'h2, 4'hE, 1'b0, 1'b0, 1'b1, 4'd13}, // R13
    '{2'd1, 8'h5E, 8'h00, 4'h0, 4'h2, 4'hE, 1'b0, 1'b1, 1'b1, 4'd13}, // R13
    '{2'd1, 8'h7C, 8'h00, 4'h0, 4'h2, 4'hD, 1'b0, 1'b0, 1'b0, 4'd13}, // R13
    '{2'd2, 8'h6E, 8'h5A, 4'hA, 4'h2, 4'hD, 1'b0, 1'b0, 1'b0, 4'd12}, // R12
    '{2'd2, 8'h6E, 8'h97, 4'hA, 4'h9, 4'hD, 1'b0, 1'b0, 1'b0, 4'd12}, // R12
    '{2'd2, 8'h6E, 8'h1F, 4'hA, 4'h9, 4'hC, 1'b0, 1'b0, 1'b1, 4'd12}, // R12
    '{2'd2, 8'h6E, 8'h35, 4'hA, 4'h9, 4'hC, 1'b0, 1'b0, 1'b1, 4'd12}, // R12 unknown sel
    '{2'd1, 8'h59, 8'h00, 4'hA, 4'h9, 4'hC, 1'b0, 1'b0, 1'b1, 4'd5},  // R5
    '{2'd2, 8'h6E, 8'hD6, 4'hA, 4'h9, 4'hC, 1'b0, 1'b1, 1'b1, 4'd12}, // R12
    '{2'd1, 8'h5A, 8'h00, 4'h0, 4'h9, 4'hC, 1'b0, 1'b1, 1'b1, 4'd5},  // R5
    '{2'd1, 8'h5D, 8'h00, 4'h0, 4'h9, 4'hC, 1'b0, 1'b0, 1'b1, 4'd13}, // R13
    '{2'd1, 8'h5A, 8'h00, 4'hF, 4'h9, 4'hC, 1'b0, 1'b0, 1'b1, 4'd5},  // R5
    '{2'd2, 8'h69, 8'h40, 4'hF, 4'h9, 4'hC, 1'b0, 1'b0, 1'b1, 4'd4},  // R4
    '{2'd1, 8'hD3, 8'h00, 4'h3, 4'h9, 4'hC, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{2'd2, 8'h69, 8'h41, 4'h3, 4'h9, 4'hC, 1'b0, 1'b0, 1'b1, 4'd4},  // R4
    '{2'd2, 8'h4E, 8'h42, 4'h3, 4'h3, 4'hF, 1'b0, 1'b0, 1'b1, 4'd7},  // R7
    '{2'd1, 8'h74, 8'h00, 4'hF, 4'h3, 4'hF, 1'b0, 1'b0, 1'b1, 4'd9},  // R9
    '{2'd1, 8'h76, 8'h00, 4'h3, 4'h3, 4'hF, 1'b0, 1'b0, 1'b1, 4'd9},  // R9
    '{2'd2, 8'h48, 8'h97, 4'h3, 4'h3, 4'hF, 1'b0, 1'b0, 1'b1, 4'd8},  // R8
    '{2'd2, 8'h49, 8'h87, 4'h3, 4'h3, 4'hF, 1'b0, 1'b0, 1'b1, 4'd8},  // R8
    '{2'd2, 8'h6A, 8'h07, 4'h1, 4'h3, 4'hF, 1'b0, 1'b0, 1'b1, 4'd4},  // R4
    '{2'd1, 8'h00, 8'h00, 4'h1, 4'h3, 4'hF, 1'b0, 1'b0, 1'b1, 4'd14}, // R14
    '{2'd2, 8'h40, 8'h00, 4'h1, 4'h3, 4'hF, 1'b0, 1'b0, 1'b1, 4'd14}, // R14
    '{2'd2, 8'h6A, 8'h2F, 4'h5, 4'h3, 4'hF, 1'b0, 1'b0, 1'b1, 4'd4}   // R4
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [7:0]      progData;
  logic [PC_W-1:0] progAddr;
  logic            retire;
  logic [3:0]      accOut, hrOut, lrOut;
  logic            carryFlag, zeroFlag, statusFlag;
  logic [7:0]      progMem [256];
  int              nChecks = 0;
  int              nFails = 0;
  bit              done = 1'b0;

  always #10 clk = ~clk;

  assign progData = progMem[progAddr];

  nib_exec_core #(.PC_W(PC_W)) dut_i (
    .clk(clk), .rstN(rstN), .progData(progData), .progAddr(progAddr),
    .retire(retire), .accOut(accOut), .hrOut(hrOut), .lrOut(lrOut),
    .carryFlag(carryFlag), .zeroFlag(zeroFlag), .statusFlag(statusFlag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] stateWord();
    return {12'h0, accOut, hrOut, lrOut, 1'b0, carryFlag, zeroFlag, statusFlag, progAddr};
  endfunction

  initial begin
    int addr = 0;
    int expPc = 0;
    logic [31:0] expWord;
    for (int i = 0; i < 256; i++) progMem[i] = 8'h00;
    for (int i = 0; i < NVEC; i++) begin
      progMem[addr] = VEC[i].b0;
      if (VEC[i].len == 2'd2) progMem[addr + 1] = VEC[i].b1;
      addr += int'(VEC[i].len);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(stateWord() == 32'h0, "R1", "state in reset", stateWord(), 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      check(retire == (VEC[i].len == 2'd1), "R2", $sformatf("retire on first byte of vector %0d", i),
            {31'h0, retire}, {31'h0, VEC[i].len == 2'd1});
      repeat (int'(VEC[i].len)) @(posedge clk);
      @(negedge clk);
      expPc += int'(VEC[i].len);
      expWord = {12'h0, VEC[i].acc, VEC[i].hr, VEC[i].lr, 1'b0,
                 VEC[i].c, VEC[i].z, VEC[i].s, 8'(expPc)};
      check(stateWord() == expWord, $sformatf("R%0d", VEC[i].req),
            $sformatf("state after vector %0d", i), stateWord(), expWord);
    end

    // R1: reset applied mid-run clears everything again
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(stateWord() == 32'h0, "R1", "state after second reset", stateWord(), 32'h0);
    rstN = 1'b1;
    // R2: first byte after reset is a one-byte opcode, retires at address 0
    check(retire && progAddr == '0, "R2", "retire at address 0",
          {23'h0, retire, progAddr}, {23'h0, 1'b1, 8'h00});

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule